// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Sequencer

This block is the host-side master for a three-wire serial non-volatile memory. A client hands it one command at a time over a valid/ready request port. Each command carries a command code, a word address and write data. The sequencer then builds the serial frame and drives chip select, serial clock and serial data towards the memory. On a read it captures the returned word. It answers every accepted request with a single-cycle response that carries the read data and an error flag.

The serial clock is derived from the system clock by a parameterised divider. Serial data changes only while the clock is low, so it is settled before every rising edge. After any programming frame the sequencer holds chip select low for a minimum number of system cycles. It then raises chip select again and watches the memory's data line until it reads ready. If ready never comes within a parameterised bound, the response carries an error. A configuration input selects byte or 16-bit word organisation. A second configuration input makes the sequencer bracket every programming command with an enable frame before it and a disable frame after it.

Top module: `serial_mem_sequencer`

## Requirements
- R1: Every frame is a start bit 1, then a two-bit opcode, then the address, all sent most significant bit first. The address is 11 bits in byte mode (`cfg_wide`=0) and 10 bits in word mode (`cfg_wide`=1). The command codes on `req_cmd` map to opcodes as follows: 0 read = 10, 1 write = 01, 2 erase = 11. The remaining codes send opcode 00, and the two top address bits carry the variant: 3 erase-all = 10, 4 write-all = 01, 5 enable = 11, 6 and 7 disable = 00.
- R2: Write and write-all frames carry their data bits after the address, most significant bit first: `req_wdata[7:0]` in byte mode and `req_wdata[15:0]` in word mode.
- R3: `mem_di` changes only while `mem_sk` is low. Rising edges of `mem_sk` within one frame are exactly 2*CLK_DIV system cycles apart.
- R4: On a read, the sequencer gives 1+W serial clocks after the address (W = 8 or 16) and samples `mem_do` at each rising edge. It drops the first sample, which is a leading dummy 0, and returns the next W bits MSB first on `rsp_rdata`. In byte mode the upper byte is zero. Non-read commands return zero.
- R5: Every rise of `mem_cs` comes after at least CS_LOW_MIN consecutive system cycles with `mem_cs` low. This includes the rise that opens the status check after a programming frame.
- R6: After a write, erase, erase-all or write-all frame, `mem_cs` is raised with `mem_sk` idle. The sequencer stays in that state until `mem_do` reads 1, then lowers `mem_cs`.
- R7: If `mem_do` stays 0 for POLL_LIMIT cycles of the status check, the sequencer ends the check and reports `rsp_err`=1. Otherwise `rsp_err` is 0.
- R8: With `cfg_auto_wp`=1, a programming command is sent as an enable frame, the command frame and a disable frame, in that order. With `cfg_auto_wp`=0, only the command frame is sent.
- R9: `req_ready` is high only when the sequencer is idle. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R10: After reset, `mem_cs`, `mem_sk`, `mem_di` and `rsp_valid` are 0 and `req_ready` is 1.
- R11: Read, enable and disable commands raise `mem_cs` once and perform no status check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_cmd | input | 3 | Command code (see R1) |
| req_addr | input | 11 | Word address (10 LSBs used in word mode) |
| req_wdata | input | 16 | Write data (8 LSBs used in byte mode) |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = bytes |
| cfg_auto_wp | input | 1 | 1 = wrap programming commands with enable/disable frames |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| rsp_err | output | 1 | Ready-poll timeout, valid with rsp_valid |
| mem_cs | output | 1 | Memory chip select |
| mem_sk | output | 1 | Memory serial clock |
| mem_di | output | 1 | Serial data towards the memory |
| mem_do | input | 1 | Serial data / ready status from the memory |

## Verification
A wrong frame builder or bit counter corrupts the address or opcode. The memory then decodes the wrong location or operation, and the fault shows within one command as a wrong read-back word or a wrong frame count. A phase register stuck on the wrong step shows up at once as a missing or extra enable/disable frame. It also shows up on the next unwrapped write, which lands or fails to land. A short chip-select gap or a data edge during a high clock is caught on the first frame it happens in. A broken poll counter shows either as a timeout with no error flag or as an error on a memory that was ready after a few hundred cycles.

// File: rtl/serial_mem_sequencer.sv
module serial_mem_sequencer #(
  parameter int CLK_DIV    = 4,
  parameter int CS_LOW_MIN = 32,
  parameter int POLL_LIMIT = 1250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_cmd,
  input  logic [10:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic        cfg_wide,
  input  logic        cfg_auto_wp,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        mem_cs,
  output logic        mem_sk,
  output logic        mem_di,
  input  logic        mem_do
);

  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int GAP_W  = $clog2(CS_LOW_MIN + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  localparam logic [2:0] CMD_READ  = 3'd0;
  localparam logic [2:0] CMD_WRITE = 3'd1;
  localparam logic [2:0] CMD_ERASE = 3'd2;
  localparam logic [2:0] CMD_ERAL  = 3'd3;
  localparam logic [2:0] CMD_WRAL  = 3'd4;
  localparam logic [2:0] CMD_EWEN  = 3'd5;
  localparam logic [2:0] CMD_EWDS  = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SHIFT, ST_POLL} state_t;

  function automatic logic is_prog(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction

  state_t             state;
  logic [2:0]         cmd_q;
  logic [10:0]        addr_q;
  logic [15:0]        wdata_q;
  logic               wide_q, wrap_q, need_poll, err_q, cs_q, sk_q, rsp_q;
  logic [1:0]         phase;
  logic [DIV_W-1:0]   cnt;
  logic [GAP_W-1:0]   gcnt, low_run;
  logic [POLL_W-1:0]  pcnt;
  logic [29:0]        sh;
  logic [4:0]         bits_left, rx_n;
  logic [15:0]        rx;

  logic [2:0]  kind;
  logic [1:0]  op, sel;
  logic        with_data;
  logic [10:0] addr_n;
  logic [9:0]  addr_w;
  logic [29:0] frame_bits;
  logic [4:0]  tx_len, rx_len;
  logic [1:0]  phase_next;

  always_comb begin
    kind = cmd_q;
    if (phase == 2'd0) kind = CMD_EWEN;
    else if (phase == 2'd2) kind = CMD_EWDS;
    op = 2'b00;
    sel = 2'b00;
    with_data = 1'b0;
    case (kind)
      CMD_READ:  op = 2'b10;
      CMD_WRITE: begin op = 2'b01; with_data = 1'b1; end
      CMD_ERASE: op = 2'b11;
      CMD_ERAL:  sel = 2'b10;
      CMD_WRAL:  begin sel = 2'b01; with_data = 1'b1; end
      CMD_EWEN:  sel = 2'b11;
      default:   sel = 2'b00;
    endcase
  end

  assign addr_n     = (op == 2'b00) ? {sel, addr_q[8:0]} : addr_q;
  assign addr_w     = (op == 2'b00) ? {sel, addr_q[7:0]} : addr_q[9:0];
  assign frame_bits = wide_q ? {1'b1, op, addr_w, wdata_q, 1'b0}
                             : {1'b1, op, addr_n, wdata_q[7:0], 8'h00};
  assign rx_len     = (kind == CMD_READ) ? (wide_q ? 5'd17 : 5'd9) : 5'd0;
  assign tx_len     = (wide_q ? 5'd13 : 5'd14) + (with_data ? (wide_q ? 5'd16 : 5'd8) : 5'd0);
  assign phase_next = (phase == 2'd0) ? 2'd1 : ((phase == 2'd1 && wrap_q) ? 2'd2 : 2'd3);

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = wide_q ? rx : {8'h00, rx[7:0]};
  assign rsp_err   = err_q;
  assign mem_cs    = cs_q;
  assign mem_sk    = sk_q;
  assign mem_di    = (state == ST_SHIFT) && (bits_left > rx_n) && sh[29];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd_q <= '0; addr_q <= '0; wdata_q <= '0;
      wide_q <= 1'b0; wrap_q <= 1'b0; need_poll <= 1'b0; err_q <= 1'b0;
      cs_q <= 1'b0; sk_q <= 1'b0; rsp_q <= 1'b0;
      phase <= 2'd0; cnt <= '0; gcnt <= '0; pcnt <= '0;
      sh <= '0; bits_left <= '0; rx_n <= '0; rx <= '0;
    end else begin
      rsp_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          cmd_q     <= req_cmd;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          wide_q    <= cfg_wide;
          wrap_q    <= cfg_auto_wp && is_prog(req_cmd);
          phase     <= (cfg_auto_wp && is_prog(req_cmd)) ? 2'd0 : 2'd1;
          need_poll <= 1'b0;
          err_q     <= 1'b0;
          rx        <= '0;
          gcnt      <= '0;
          state     <= ST_GAP;
        end
        ST_GAP: if (gcnt == GAP_W'(CS_LOW_MIN - 1)) begin
          gcnt <= '0;
          if (need_poll) begin
            cs_q  <= 1'b1;
            pcnt  <= '0;
            state <= ST_POLL;
          end else if (phase == 2'd3) begin
            rsp_q <= 1'b1;
            state <= ST_IDLE;
          end else begin
            sh        <= frame_bits;
            bits_left <= tx_len + rx_len;
            rx_n      <= rx_len;
            rx        <= '0;
            cnt       <= '0;
            cs_q      <= 1'b1;
            state     <= ST_SHIFT;
          end
        end else begin
          gcnt <= gcnt + 1'b1;
        end
        ST_SHIFT: if (cnt != DIV_W'(CLK_DIV - 1)) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!sk_q) begin
            sk_q <= 1'b1;
            if (bits_left <= rx_n) rx <= {rx[14:0], mem_do};
          end else begin
            sk_q      <= 1'b0;
            sh        <= {sh[28:0], 1'b0};
            bits_left <= bits_left - 1'b1;
            if (bits_left == 5'd1) begin
              cs_q  <= 1'b0;
              gcnt  <= '0;
              state <= ST_GAP;
              if (phase == 2'd1 && is_prog(cmd_q)) need_poll <= 1'b1;
              phase <= phase_next;
            end
          end
        end
        ST_POLL: if (mem_do || pcnt == POLL_W'(POLL_LIMIT - 1)) begin
          if (!mem_do) err_q <= 1'b1;
          cs_q      <= 1'b0;
          need_poll <= 1'b0;
          gcnt      <= '0;
          state     <= ST_GAP;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (cs_q) low_run <= '0;
    else if (low_run != GAP_W'(CS_LOW_MIN)) low_run <= low_run + 1'b1;
  end

  a_r3_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sk && $past(mem_sk)) |-> $stable(mem_di));
  a_r6_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sk |-> mem_cs);
  a_r5_cs_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> (low_run >= GAP_W'(CS_LOW_MIN)));
  a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r7_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> (pcnt < POLL_W'(POLL_LIMIT)));

endmodule

// File: tb/sim_serial_mem_sequencer.sv
`timescale 1ns/1ps
module sim_serial_mem_sequencer;
  localparam int DIV = 2;
  localparam int CSL = 5;
  localparam int PLIM = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic cfg_wide = 1'b0, cfg_auto_wp = 1'b0;
  logic req_ready, rsp_valid, rsp_err, mem_cs, mem_sk, mem_di, mem_do;
  logic [15:0] rsp_rdata;

  always #4 clk = ~clk;

  serial_mem_sequencer #(.CLK_DIV(DIV), .CS_LOW_MIN(CSL), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_wide(cfg_wide), .cfg_auto_wp(cfg_auto_wp), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mem_cs(mem_cs), .mem_sk(mem_sk),
    .mem_di(mem_di), .mem_do(mem_do));

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  // memory model
  logic [15:0] arr [2048];
  logic sk_p, cs_p, m_started, m_out, m_stat, m_pend, m_en;
  logic [31:0] m_sh;
  logic [16:0] m_osh;
  int m_n, m_busy, m_frames, m_rises, busy_len;
  int b_low, min_low, stat_rises, last_rise, per_bad, di_bad, cyc;
  logic di_p;

  assign mem_do = m_stat ? (m_busy == 0) : (m_out ? m_osh[16] : 1'b0);

  always @(posedge clk) begin
    int aw, dw, n;
    logic [31:0] nx;
    logic [10:0] a;
    logic [15:0] d;
    logic [1:0] op, top;
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) arr[i] <= init_word(i);
      sk_p <= 0; cs_p <= 0; m_started <= 0; m_out <= 0; m_stat <= 0; m_pend <= 0; m_en <= 0;
      m_sh <= 0; m_osh <= 0; m_n <= 0; m_busy <= 0; m_frames <= 0; m_rises <= 0;
      b_low <= 0; min_low <= 1 << 30; stat_rises <= 0; last_rise <= 0; per_bad <= 0;
      di_bad <= 0; cyc <= 0; di_p <= 0;
    end else begin
      cyc <= cyc + 1;
      sk_p <= mem_sk; cs_p <= mem_cs; di_p <= mem_di;
      if (mem_sk && sk_p && mem_di != di_p) di_bad <= di_bad + 1;
      if (m_busy > 0) m_busy <= m_busy - 1;
      if (!mem_cs) b_low <= b_low + 1;
      if (!mem_cs && cs_p) begin m_started <= 0; m_out <= 0; m_stat <= 0; end
      if (mem_cs && !cs_p) begin
        m_rises <= m_rises + 1;
        if (m_pend) begin
          stat_rises <= stat_rises + 1;
          if (b_low < min_low) min_low <= b_low;
        end
        m_stat <= m_pend; m_pend <= 0; b_low <= 0; last_rise <= 0;
      end
      if (mem_cs && mem_sk && !sk_p) begin
        if (last_rise != 0 && cyc - last_rise != 2 * DIV) per_bad <= per_bad + 1;
        last_rise <= cyc;
        if (m_out) m_osh <= m_osh << 1;
        else if (!m_started) begin
          if (mem_di) begin m_started <= 1; m_n <= 0; m_sh <= 0; m_frames <= m_frames + 1; end
        end else begin
          aw = cfg_wide ? 10 : 11;
          dw = cfg_wide ? 16 : 8;
          nx = {m_sh[30:0], mem_di};
          n = m_n + 1;
          m_sh <= nx; m_n <= n;
          if (n == 2 + aw) begin
            op = nx[aw+1 -: 2];
            a = cfg_wide ? {1'b0, nx[9:0]} : nx[10:0];
            top = cfg_wide ? a[9:8] : a[10:9];
            if (op == 2'b10) begin
              m_out <= 1;
              m_osh <= cfg_wide ? {1'b0, arr[a]} : {1'b0, arr[a][7:0], 8'h00};
            end else if (op == 2'b11) begin
              if (m_en) arr[a] <= 16'hFFFF;
              m_busy <= m_en ? busy_len : 0; m_pend <= 1;
            end else if (op == 2'b00) begin
              if (top == 2'b11) m_en <= 1;
              else if (top == 2'b00) m_en <= 0;
              else if (top == 2'b10) begin
                if (m_en) for (int i = 0; i < 2048; i++) arr[i] <= 16'hFFFF;
                m_busy <= m_en ? busy_len : 0; m_pend <= 1;
              end
            end
          end
          if (n == 2 + aw + dw) begin
            op = nx[aw+dw+1 -: 2];
            a = cfg_wide ? {1'b0, nx[25:16]} : nx[18:8];
            d = cfg_wide ? nx[15:0] : {8'h00, nx[7:0]};
            top = cfg_wide ? a[9:8] : a[10:9];
            if (op == 2'b01 || (op == 2'b00 && top == 2'b01)) begin
              if (m_en) begin
                if (op == 2'b01) arr[a] <= d;
                else for (int i = 0; i < 2048; i++) arr[i] <= d;
              end
              m_busy <= m_en ? busy_len : 0; m_pend <= 1;
            end
          end
        end
      end
    end
  end

  // scoreboard
  logic [15:0] q_d[$];
  logic q_e[$];
  string q_t[$];
  logic [15:0] shadow [2048];
  logic sh_en;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_d.size() == 0) chk("R9 unexpected response", 1, 0);
      else begin
        chk({q_t[0], " rdata"}, {16'h0, rsp_rdata}, {16'h0, q_d[0]});
        chk({q_t[0], " R7 err"}, {31'h0, rsp_err}, {31'h0, q_e[0]});
        void'(q_d.pop_front()); void'(q_e.pop_front()); q_t.pop_front();
      end
    end
  end

  task automatic run(input logic [2:0] c, input logic [10:0] a, input logic [15:0] d,
                     input logic aut, input logic exp_err, input int exp_fr,
                     input int exp_ri, input string tag);
    logic [15:0] er;
    logic ok;
    int idx, f0, r0, wait_n;
    idx = cfg_wide ? int'(a[9:0]) : int'(a);
    er = 16'h0;
    ok = aut || sh_en;
    case (c)
      3'd0: er = cfg_wide ? shadow[idx] : {8'h00, shadow[idx][7:0]};
      3'd1: if (ok) shadow[idx] = cfg_wide ? d : {8'h00, d[7:0]};
      3'd2: if (ok) shadow[idx] = 16'hFFFF;
      3'd3: if (ok) for (int i = 0; i < 2048; i++) shadow[i] = 16'hFFFF;
      3'd4: if (ok) for (int i = 0; i < 2048; i++) shadow[i] = cfg_wide ? d : {8'h00, d[7:0]};
      3'd5: sh_en = 1;
      default: sh_en = 0;
    endcase
    if (aut && c >= 3'd1 && c <= 3'd4) sh_en = 0;
    q_d.push_back(er); q_e.push_back(exp_err); q_t.push_back(tag);
    f0 = m_frames; r0 = m_rises;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_wdata = d; cfg_auto_wp = aut; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_n = 0;
    while (q_d.size() != 0 && wait_n < 20000) begin @(negedge clk); wait_n++; end
    chk({tag, " R8 frames"}, m_frames - f0, exp_fr);
    chk({tag, " R11 cs rises"}, m_rises - r0, exp_ri);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) shadow[i] = init_word(i);
    sh_en = 0;
    busy_len = 200;
    repeat (3) @(negedge clk);
    chk("R10 cs", mem_cs, 0); chk("R10 sk", mem_sk, 0); chk("R10 di", mem_di, 0);
    chk("R10 ready", req_ready, 1); chk("R10 rsp_valid", rsp_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // byte mode
    run(3'd0, 11'd5,   16'h0,    0, 0, 1, 1, "R4 byte read");
    run(3'd1, 11'd7,   16'h00A5, 0, 0, 1, 2, "R6 write while disabled");
    run(3'd0, 11'd7,   16'h0,    0, 0, 1, 1, "R1 read unchanged");
    run(3'd5, 11'd0,   16'h0,    0, 0, 1, 1, "R11 enable");
    run(3'd1, 11'd7,   16'h003C, 0, 0, 1, 2, "R2 byte write");
    run(3'd0, 11'd7,   16'h0,    0, 0, 1, 1, "R2 byte readback");
    run(3'd6, 11'd0,   16'h0,    0, 0, 1, 1, "R11 disable");
    run(3'd1, 11'd7,   16'h0011, 0, 0, 1, 2, "R1 write after disable");
    run(3'd0, 11'd7,   16'h0,    0, 0, 1, 1, "R1 disable held");
    run(3'd1, 11'h7FF, 16'h00C3, 1, 0, 3, 4, "R8 wrapped write");
    run(3'd0, 11'h7FF, 16'h0,    0, 0, 1, 1, "R1 top address readback");
    run(3'd1, 11'd7,   16'h0099, 0, 0, 1, 2, "R8 disabled after wrap");
    run(3'd0, 11'd7,   16'h0,    0, 0, 1, 1, "R8 readback unchanged");
    run(3'd2, 11'd9,   16'h0,    1, 0, 3, 4, "R6 wrapped erase");
    run(3'd0, 11'd9,   16'h0,    0, 0, 1, 1, "R1 erased byte");
    // word mode
    cfg_wide = 1;
    run(3'd0, 11'd5,   16'h0,    0, 0, 1, 1, "R4 word read");
    run(3'd1, 11'h3FF, 16'hBEEF, 1, 0, 3, 4, "R2 word write");
    run(3'd0, 11'h3FF, 16'h0,    0, 0, 1, 1, "R4 word readback");
    run(3'd4, 11'd0,   16'h1234, 1, 0, 3, 4, "R1 write-all");
    run(3'd0, 11'd0,   16'h0,    0, 0, 1, 1, "R1 write-all at 0");
    run(3'd0, 11'h200, 16'h0,    0, 0, 1, 1, "R1 write-all at 0x200");
    run(3'd3, 11'd0,   16'h0,    1, 0, 3, 4, "R1 erase-all");
    run(3'd0, 11'd5,   16'h0,    0, 0, 1, 1, "R1 erase-all readback");
    busy_len = 3000;
    run(3'd1, 11'h010, 16'h0F0F, 1, 1, 3, 4, "R7 poll timeout");
    repeat (3200) @(negedge clk);
    busy_len = 200;
    chk("R3 clock period errors", per_bad, 0);
    chk("R3 data edges while clock high", di_bad, 0);
    chk("R5 status checks seen", {31'h0, stat_rises > 0}, 1);
    chk("R5 cs low before status", {31'h0, min_low >= CSL}, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule